// File: doc/BRIEF.md
# Programmable Serial CRC Unit

This block computes cyclic redundancy checks one bit at a time alongside a serial shift register. It holds a programmable generator polynomial and two independent accumulators: one follows the bits being sent, the other follows the bits being received. Both accumulators advance on the same shift strobe. Each one takes its own data bit.

A width input selects an 8-bit or a 16-bit checksum. Software loads the polynomial through a write strobe and reads the polynomial and both results back on plain output ports. Writing a 1 to the enable control turns the unit on and also clears both results. A busy output is high while a frame is only partly shifted. Results should be read only while busy is low.

Top module: `serial_crc_unit`

## Requirements
- R1: After reset the polynomial output reads 0x0007. It keeps its value in every cycle without a polynomial write.
- R2: A polynomial write stores the full 16-bit data value. The new value is visible and used from the next cycle. A shift in the same cycle as the write still uses the old polynomial.
- R3: While enabled, each shift strobe updates the transmit result, taking the data most significant bit first. The feedback bit is the result's top bit (bit 7 in 8-bit mode, bit 15 in 16-bit mode) XOR the transmit bit. The result shifts left by one and is XORed with the polynomial when the feedback bit is 1.
- R4: The receive result follows the same rule as R3, using the receive bit, on the same strobe.
- R5: While the enable control is 0, shift strobes leave both results and busy unchanged.
- R6: Writing 1 to the enable control clears both results and busy in the next cycle. This applies even when the unit is already enabled and a shift strobe arrives in the same cycle.
- R7: In 8-bit mode (wide = 0) only polynomial bits 7:0 take part in the computation, and result bits 15:8 read as zero.
- R8: In 16-bit mode (wide = 1) all 16 polynomial and result bits take part.
- R9: Busy is high while the number of accepted shifts since the last frame boundary is not zero. A frame is 8 shifts in 8-bit mode and 16 shifts in 16-bit mode. Busy drops in the cycle after the last shift of a frame.
- R10: After reset both results read 0x0000, the enable control is 0, and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poly_wr | input | 1 | Polynomial write strobe |
| poly_wdata | input | 16 | Polynomial write data |
| en_wr | input | 1 | Enable control write strobe |
| en_wdata | input | 1 | Enable value written; 1 also clears the results |
| wide | input | 1 | 0 selects 8-bit, 1 selects 16-bit |
| shift_en | input | 1 | One-bit shift strobe |
| tx_bit | input | 1 | Outgoing line data bit |
| rx_bit | input | 1 | Incoming line data bit |
| poly_q | output | 16 | Stored polynomial |
| tx_crc | output | 16 | Transmit-side result |
| rx_crc | output | 16 | Receive-side result |
| busy | output | 1 | Frame in progress |

## Verification
Two events can fall in the same cycle. The first is a clearing enable write arriving together with a shift strobe. The second is a polynomial write arriving together with a shift. The bench drives both collisions on purpose, part-way through a frame. It expects zeroed results and low busy after the clear. After the polynomial write it expects the step to be taken with the previous polynomial. A behavioural integer model applies the same precedence independently, and every cycle all four outputs are compared against it.

// File: rtl/serial_crc_unit.sv
module serial_crc_unit #(
  parameter int W = 16,
  parameter int NW = 8,
  parameter logic [15:0] POLY_RST = 16'h0007
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         poly_wr,
  input  logic [W-1:0] poly_wdata,
  input  logic         en_wr,
  input  logic         en_wdata,
  input  logic         wide,
  input  logic         shift_en,
  input  logic         tx_bit,
  input  logic         rx_bit,
  output logic [W-1:0] poly_q,
  output logic [W-1:0] tx_crc,
  output logic [W-1:0] rx_crc,
  output logic         busy
);
  localparam int CW = $clog2(W);
  localparam logic [W-1:0] NMASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic [W-1:0]  poly_r, tx_r, rx_r, mask;
  logic          en_r, clr, step;
  logic [CW-1:0] cnt_r;
  int            lim;

  assign clr  = en_wr & en_wdata;
  assign step = shift_en & en_r & ~clr;
  assign mask = wide ? '1 : NMASK;
  assign lim  = wide ? W : NW;

  function automatic logic [W-1:0] adv(input logic [W-1:0] acc, input logic d,
                                       input logic [W-1:0] p, input logic wd,
                                       input logic [W-1:0] m);
    logic fb;
    fb = (wd ? acc[W-1] : acc[NW-1]) ^ d;
    return ({acc[W-2:0], 1'b0} ^ (fb ? p : '0)) & m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) poly_r <= POLY_RST;
    else if (poly_wr) poly_r <= poly_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_r <= 1'b0;
    else if (en_wr) en_r <= en_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      tx_r  <= '0;
      rx_r  <= '0;
      cnt_r <= '0;
    end else if (step) begin
      tx_r  <= adv(tx_r, tx_bit, poly_r, wide, mask);
      rx_r  <= adv(rx_r, rx_bit, poly_r, wide, mask);
      cnt_r <= (int'(cnt_r) + 1 >= lim) ? '0 : cnt_r + 1'b1;
    end
  end

  assign poly_q = poly_r;
  assign tx_crc = tx_r & mask;
  assign rx_crc = rx_r & mask;
  assign busy   = (cnt_r != '0);
endmodule

module serial_crc_unit_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         poly_wr,
  input logic [W-1:0] poly_wdata,
  input logic         en_wr,
  input logic         en_wdata,
  input logic         wide,
  input logic         shift_en,
  input logic [W-1:0] poly_q,
  input logic [W-1:0] tx_crc,
  input logic [W-1:0] rx_crc,
  input logic         busy
);
  p_poly_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !poly_wr |=> $stable(poly_q));
  p_poly_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    poly_wr |=> poly_q == $past(poly_wdata));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !en_wr) |=> (!$stable(wide) || ($stable(tx_crc) && $stable(rx_crc))));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && en_wdata) |=> (tx_crc == '0 && rx_crc == '0 && !busy));
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (tx_crc[W-1:8] == '0 && rx_crc[W-1:8] == '0));
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !en_wr) |=> $stable(busy));
endmodule

bind serial_crc_unit serial_crc_unit_chk #(.W(W)) u_chk (.*);

// File: tb/serial_crc_unit_tb_top.sv
module serial_crc_unit_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, poly_wr, en_wr, en_wdata, wide, shift_en, tx_bit, rx_bit, busy;
  logic [15:0] poly_wdata, poly_q, tx_crc, rx_crc;

  serial_crc_unit dut_i (.*);

  int vectors = 0, misses = 0;
  int m_poly, m_tx, m_rx, m_en, m_cnt;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int step_ref(input int acc, input int d, input int p, input int w);
    int fb;
    fb = ((acc >> (w - 1)) & 1) ^ d;
    acc = acc << 1;
    if (fb != 0) acc = acc ^ p;
    return acc & ((1 << w) - 1);
  endfunction

  task automatic cyc(input bit sh, input bit tb, input bit rb);
    int w, msk;
    shift_en = sh; tx_bit = tb; rx_bit = rb;
    @(posedge clk);
    w = wide ? 16 : 8;
    msk = (1 << w) - 1;
    if (!rst_n) begin
      m_poly = 16'h0007; m_tx = 0; m_rx = 0; m_en = 0; m_cnt = 0;
    end else begin
      if (en_wr && en_wdata) begin
        m_tx = 0; m_rx = 0; m_cnt = 0;
      end else if (sh && m_en != 0) begin
        m_tx = step_ref(m_tx & msk, tb, m_poly, w);
        m_rx = step_ref(m_rx & msk, rb, m_poly, w);
        m_cnt = (m_cnt + 1 >= w) ? 0 : m_cnt + 1;
      end
      if (poly_wr) m_poly = poly_wdata;
      if (en_wr) m_en = en_wdata;
    end
    #1;
    w = wide ? 16 : 8;
    msk = (1 << w) - 1;
    chk("R1/R2 poly_q", poly_q, m_poly);
    chk("R3 tx_crc", tx_crc, m_tx & msk);
    chk("R4 rx_crc", rx_crc, m_rx & msk);
    chk("R9 busy", busy, m_cnt != 0);
    poly_wr = 0; en_wr = 0;
  endtask

  task automatic frame(input int tv, input int rv, input int n);
    for (int i = n - 1; i >= 0; i--) cyc(1'b1, tv[i], rv[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 0; poly_wr = 0; poly_wdata = 0; en_wr = 0; en_wdata = 0; wide = 0;
    shift_en = 0; tx_bit = 0; rx_bit = 0;
    repeat (3) cyc(1'b0, 1'b0, 1'b0);
    rst_n = 1;
    cyc(1'b0, 1'b0, 1'b0);
    chk("R10 tx reset", tx_crc, 0);
    chk("R10 rx reset", rx_crc, 0);
    chk("R1 poly reset", poly_q, 16'h0007);
    // R5: no enable yet, shifts ignored
    frame(8'hFF, 8'hFF, 4);
    chk("R5 disabled tx", tx_crc, 0);
    chk("R5 disabled busy", busy, 0);
    en_wr = 1; en_wdata = 1; cyc(1'b0, 1'b0, 1'b0);
    // R3 hand value: byte 0x01 with poly 0x07 gives 0x07
    frame(8'h01, 8'hA5, 8);
    chk("R3 crc8 of 0x01", tx_crc, 16'h0007);
    chk("R9 busy after frame", busy, 0);
    for (int k = 0; k < 6; k++) frame($urandom, $urandom, 8);
    // R2 collision: polynomial write with a shift mid-frame
    frame($urandom, $urandom, 3);
    poly_wr = 1; poly_wdata = 16'hA31D; cyc(1'b1, 1'b1, 1'b0);
    frame($urandom, $urandom, 4);
    chk("R7 upper bits zero", tx_crc[15:8], 0);
    for (int k = 0; k < 4; k++) frame($urandom, $urandom, 8);
    // R5: disable, shift, results hold
    en_wr = 1; en_wdata = 0; cyc(1'b0, 1'b0, 1'b0);
    frame($urandom, $urandom, 5);
    en_wr = 1; en_wdata = 1; cyc(1'b0, 1'b0, 1'b0);
    // R6 collision: clear with a shift while enabled, mid-frame
    frame($urandom, $urandom, 5);
    en_wr = 1; en_wdata = 1; cyc(1'b1, 1'b1, 1'b1);
    chk("R6 clear tx", tx_crc, 0);
    chk("R6 clear rx", rx_crc, 0);
    chk("R6 clear busy", busy, 0);
    // R8: 16-bit mode, two polynomials
    wide = 1;
    poly_wr = 1; poly_wdata = 16'h8005; cyc(1'b0, 1'b0, 1'b0);
    frame(16'h0001, 16'h0001, 16);
    chk("R8 crc16 of 0x0001", tx_crc, 16'h8005);
    for (int k = 0; k < 5; k++) frame($urandom, $urandom, 16);
    poly_wr = 1; poly_wdata = 16'h1021; cyc(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) frame($urandom, $urandom, 16);
    chk("R9 idle after 16", busy, 0);
    // back to 8 bits: low byte of 0x1021 used
    wide = 0; en_wr = 1; en_wdata = 1; cyc(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) frame($urandom, $urandom, 8);
    chk("R7 rx upper zero", rx_crc[15:8], 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule